// File: doc/BRIEF.md
# Last-In First-Out Sample Buffer with Overflow and Empty Reporting

This block sits between an acquisition source that produces samples in bursts and a slower consumer that drains them. It holds up to sixteen samples in a stack addressed by one up/down pointer. A push stores the incoming sample at the pointer position and moves the pointer up. A pop reads the entry just beneath the pointer and moves the pointer down, so the newest sample is always returned first.

Nothing stalls at either end. A push that arrives with the store full is thrown away, and a sticky overflow flag tells the consumer that data was lost. The flag stays set until the consumer clears it. A pop on an empty store returns no sample, and its valid indication stays low for that cycle. When a push and a pop arrive in the same cycle, the pop is served first and the push second. The returned sample is the old top entry, and the new sample takes its place.

Top module: `sample_lifo`

## Requirements
- R1: After synchronous active-low reset the store is empty, `ovf_flag` is 0 and `pop_valid` is 0.
- R2: A push with `push_valid`=1 and no pop stores `push_data` when fewer than DEPTH (16) samples are held. Pops return stored samples newest first.
- R3: A push with no pop while 16 samples are held is discarded. The stored contents and the fill level are unchanged.
- R4: A discarded push sets `ovf_flag` in the following cycle. The flag then stays 1 while `ovf_clr` is 0.
- R5: `ovf_clr`=1 clears `ovf_flag` in the next cycle, except when a push is discarded in that same cycle; in that case the flag stays 1.
- R6: A pop on an empty store gives `pop_valid`=0 in the next cycle and leaves the fill level unchanged.
- R7: A successful pop gives `pop_valid`=1 in the next cycle, with `pop_data` equal to the newest stored sample. In every other cycle `pop_valid` is 0 and `pop_data` holds its last value.
- R8: A push and a pop in the same cycle with a non-empty store return the previous newest sample. The pushed sample replaces it and the fill level is unchanged.
- R9: A push and a pop in the same cycle with an empty store report empty (`pop_valid`=0), and the pushed sample is stored.
- R10: A push and a pop in the same cycle with a full store do not set `ovf_flag`. The pushed sample replaces the newest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Acquisition event: store `push_data` this cycle |
| push_data | input | WIDTH (8) | Sample to store |
| pop_req | input | 1 | Consumer requests the newest sample |
| pop_valid | output | 1 | `pop_data` carries a sample delivered this cycle |
| pop_data | output | WIDTH (8) | Most recently delivered sample |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky indication that a sample was dropped |

## Verification
The bench builds the block with its default parameters, DEPTH 16 and WIDTH 8. At this size every fill level from empty to full can be reached in a short sweep. For each fill level the bench pushes samples with arithmetically generated values and drains them all. It then checks the order in which they come back and the empty pop that follows. At the full level it adds discarded pushes, and it places the same-cycle push and pop at the empty, partly filled and full boundaries.

// File: rtl/sample_lifo_pkg.sv
// Package: shared operation encoding for the sample LIFO.
// Assumes: consumers decode the op from the push and pop request pair.
package sample_lifo_pkg;

    // Request combination seen by the pointer logic in one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } lifo_op_e;

    // Packs the two request lines into an operation code
    function automatic lifo_op_e make_op(input logic push, input logic pop);
        return lifo_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/lifo_ptr.sv
// Module: lifo_ptr
// Holds the single up/down fill pointer and decides, each cycle, whether
// the pop and the push are served and where the write goes.
// Assumes: the pop is served before the push within one cycle.
module lifo_ptr
    import sample_lifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH) + 1,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic             pop_req,
    output logic [PTR_W-1:0] ptr,
    output logic             do_pop,
    output logic             do_push,
    output logic             drop,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);

    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

    lifo_op_e         op;
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] ptr_nxt;
    logic             is_empty;

    // Decode the request pair and derive the served operations
    always_comb begin
        op       = make_op(push_valid, pop_req);
        is_empty = (ptr == '0);
        do_pop   = 1'b0;
        base     = ptr;
        case (op)
            OP_POP, OP_SWAP: begin
                do_pop = !is_empty;
                base   = is_empty ? ptr : ptr - PTR_W'(1);
            end
            default: begin
                do_pop = 1'b0;
                base   = ptr;
            end
        endcase
        do_push = push_valid && (base != FULL_LVL);
        drop    = push_valid && !do_push;
        wr_idx  = base[IDX_W-1:0];
        rd_idx  = IDX_W'(ptr - PTR_W'(1));
        ptr_nxt = base + PTR_W'(do_push);
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

endmodule

// File: rtl/lifo_store.sv
// Module: lifo_store
// Register array of DEPTH samples with one write port and one
// combinational read port.
// Assumes: the read sees the contents held before this cycle's write.
module lifo_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] cells [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        // One entry: loads when it is the addressed write target
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cells[gi] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(gi)))    cells[gi] <= wr_data;
        end
    end

    // Read multiplexer
    always_comb rd_data = cells[rd_idx];

endmodule

// File: rtl/lifo_ovf.sv
// Module: lifo_ovf
// Sticky overflow flag: set by a dropped sample, cleared on request.
// Assumes: a drop in the same cycle as a clear keeps the flag set.
module lifo_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    // Flag register with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (drop) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

endmodule

// File: rtl/sample_lifo.sv
// Module: sample_lifo (top)
// Sixteen-deep last-in first-out sample buffer that never stalls.
// Dropped pushes raise a sticky overflow flag, and an empty pop leaves
// pop_valid low.
// Assumes: a synchronous active-low reset; all outputs are registered.
module sample_lifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    input  logic             ovf_clr,
    output logic             ovf_flag
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] ptr;
    logic             do_pop;
    logic             do_push;
    logic             drop;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [WIDTH-1:0] rd_data;

    lifo_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(push_valid),
        .pop_req   (pop_req),
        .ptr       (ptr),
        .do_pop    (do_pop),
        .do_push   (do_push),
        .drop      (drop),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx)
    );

    lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_push),
        .wr_idx (wr_idx),
        .wr_data(push_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    lifo_ovf u_ovf (
        .clk  (clk),
        .rst_n(rst_n),
        .drop (drop),
        .clr  (ovf_clr),
        .flag (ovf_flag)
    );

    // Output stage: capture the popped sample and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            pop_valid <= do_pop;
            if (do_pop) pop_data <= rd_data;
        end
    end

endmodule

// File: rtl/sample_lifo_chk.sv
// Checker for sample_lifo, attached by bind; it observes the ports and the
// fill pointer.
module sample_lifo_chk #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_req,
    input logic             pop_valid,
    input logic             ovf_clr,
    input logic             ovf_flag,
    input logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

    assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= FULL_LVL);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop_req && ptr == FULL_LVL) |=> $stable(ptr));

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop_req && ptr == FULL_LVL) |=> ovf_flag);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(push_valid && !pop_req && ptr == FULL_LVL)) |=> !ovf_flag);

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && ptr == '0) |=> !pop_valid);

    assert_pop_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && ptr != '0) |=> pop_valid);

    assert_no_pop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !pop_valid);

    assert_swap_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop_req && ptr != '0) |=> $stable(ptr));

    assert_full_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop_req && ptr == FULL_LVL && !ovf_flag && !ovf_clr) |=> !ovf_flag);

endmodule

bind sample_lifo sample_lifo_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(push_valid),
    .pop_req   (pop_req),
    .pop_valid (pop_valid),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag),
    .ptr       (ptr)
);

// File: tb/sim_sample_lifo.sv
`timescale 1ns/1ps
// Bench: sweeps every fill level of the default 16 x 8 configuration,
// checks the order in which samples return and covers the boundaries.
module sim_sample_lifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       pop_valid;
    logic [7:0] pop_data;
    logic       ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sample_lifo #(.DEPTH(16), .WIDTH(8)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(push_valid),
        .push_data (push_data),
        .pop_req   (pop_req),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .ovf_clr   (ovf_clr),
        .ovf_flag  (ovf_flag)
    );

    // Sample value for fill level n, position i
    function automatic logic [7:0] val(input int n, input int i);
        return 8'((n * 29 + i * 7 + 3) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at a falling edge; return at the next falling edge
    task automatic cyc(input logic pv, input logic [7:0] pd, input logic pr, input logic clr);
        push_valid = pv; push_data = pd; pop_req = pr; ovf_clr = clr;
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 pop_valid", int'(pop_valid), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
        cyc(0, 0, 1, 0);
        chk("R1 empty after reset", int'(pop_valid), 0);

        // Sweep every fill level
        for (int n = 0; n <= 16; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) cyc(1, val(n, i), 0, 0);
            chk("R2 no ovf below full", int'(ovf_flag), 0);
            if (n == 16) begin
                cyc(1, 8'hAA, 0, 0);
                chk("R4 ovf set", int'(ovf_flag), 1);
                cyc(1, 8'h55, 0, 0);
                cyc(0, 0, 0, 0);
                chk("R4 ovf sticky", int'(ovf_flag), 1);
            end
            for (int k = 0; k < n; k++) begin
                cyc(0, 0, 1, 0);
                chk("R7 valid", int'(pop_valid), 1);
                chk(n == 16 ? "R3 contents kept" : "R2 lifo order",
                    int'(pop_data), int'(val(n, n - 1 - k)));
            end
            cyc(0, 0, 1, 0);
            chk("R6 empty pop", int'(pop_valid), 0);
            if (n > 0) chk("R7 data held", int'(pop_data), int'(val(n, 0)));
            cyc(0, 0, 0, 0);
            chk("R7 idle no valid", int'(pop_valid), 0);
            if (n == 16) begin
                cyc(0, 0, 0, 1);
                chk("R5 ovf cleared", int'(ovf_flag), 0);
            end
        end

        // Clear and a dropped push in the same cycle
        do_reset();
        for (int i = 0; i < 16; i++) cyc(1, val(3, i), 0, 0);
        cyc(1, 8'h11, 0, 1);
        chk("R5 drop beats clear", int'(ovf_flag), 1);

        // Empty pop leaves the level unchanged
        do_reset();
        cyc(0, 0, 1, 0);
        cyc(1, 8'd5, 0, 0);
        cyc(0, 0, 1, 0);
        chk("R6 level kept valid", int'(pop_valid), 1);
        chk("R6 level kept data", int'(pop_data), 5);
        cyc(0, 0, 1, 0);
        chk("R6 empty again", int'(pop_valid), 0);

        // Same-cycle push and pop, partly filled
        do_reset();
        cyc(1, 8'd10, 0, 0); cyc(1, 8'd20, 0, 0); cyc(1, 8'd30, 0, 0);
        cyc(1, 8'd99, 1, 0);
        chk("R8 swap valid", int'(pop_valid), 1);
        chk("R8 swap old top", int'(pop_data), 30);
        cyc(0, 0, 1, 0); chk("R8 new top", int'(pop_data), 99);
        cyc(0, 0, 1, 0); chk("R8 next", int'(pop_data), 20);
        cyc(0, 0, 1, 0); chk("R8 bottom", int'(pop_data), 10);
        cyc(0, 0, 1, 0); chk("R8 level kept", int'(pop_valid), 0);

        // Same-cycle push and pop, empty
        do_reset();
        cyc(1, 8'd55, 1, 0);
        chk("R9 empty swap", int'(pop_valid), 0);
        cyc(0, 0, 1, 0);
        chk("R9 stored valid", int'(pop_valid), 1);
        chk("R9 stored data", int'(pop_data), 55);
        cyc(0, 0, 1, 0);
        chk("R9 then empty", int'(pop_valid), 0);

        // Same-cycle push and pop, full
        do_reset();
        for (int i = 0; i < 16; i++) cyc(1, val(16, i), 0, 0);
        cyc(1, 8'h77, 1, 0);
        chk("R10 old top", int'(pop_data), int'(val(16, 15)));
        chk("R10 no ovf", int'(ovf_flag), 0);
        cyc(0, 0, 1, 0); chk("R10 replaced", int'(pop_data), 8'h77);
        cyc(0, 0, 1, 0); chk("R10 below", int'(pop_data), int'(val(16, 14)));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule